// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block is a synchronous controller that performs single-byte write cycles on an external asynchronous static RAM. A host hands it an address and a data byte over a valid/ready port. The controller then drives the memory's active-low chip select, write strobe and read-output enable, along with the address bus and a data bus that has its own driver-enable. Every timing interval of the write is produced by counting clock cycles. Each minimum time from the 70 ns speed grade is rounded up to whole cycles of a 5 ns clock and held as a parameter.

Each write has four parts. First the address is put on the bus while both enables are high (setup). Then the write strobe and chip select fall together, and the data driver turns on. The strobe is held low long enough to cover the pulse-width, chip-select-to-end, address-to-end and data-valid minimums. The write always ends on the write strobe. Chip select and the data driver stay active for one more cycle of hold. The address is then held until the full cycle time has elapsed. The memory's read-output enable is never asserted, and chip select never falls before the write strobe. As a result, the memory never drives the shared data lines during a write.

Back-pressure rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle. It goes low on the edge that accepts a request and stays low until the whole write cycle has finished. While `req_ready` is low, `req_valid`, `req_addr` and `req_data` are ignored. A host that keeps `req_valid` high is served again on the first cycle in which `req_ready` returns.

Top module: `sram_write_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `wr_done` is 0, and `mem_addr` and `mem_dq_o` are 0.
- R2: A request is accepted on a rising edge with `req_valid` = 1 and `req_ready` = 1. `req_ready` is 0 for the 15 cycles after that edge and returns to 1 in the 16th cycle. Requests presented while `req_ready` is 0 are ignored.
- R3: `mem_addr` shows the accepted address from the first cycle after acceptance. It stays unchanged until the next accepted request, including while the controller is idle.
- R4: Counting cycle 0 as the cycle right after the accepting edge, `mem_we_n` is 0 exactly in cycles 1 to 13 (13 cycles, 65 ns) and 1 at all other times.
- R5: `mem_ce_n` is 0 exactly in cycles 1 to 14. It falls in the same cycle as `mem_we_n` and rises one cycle after `mem_we_n` rises.
- R6: `mem_dq_oe` is 1 exactly in cycles 1 to 14. While it is 1, `mem_dq_o` carries the accepted data byte.
- R7: `mem_oe_n` stays 1 at all times.
- R8: `wr_done` is 1 for exactly one cycle, in cycle 14, and `req_ready` is 1 in the cycle that follows.
- R9: With `req_valid` held high, a second request is accepted on the first edge at which `req_ready` is 1. Its address appears in the next cycle, 16 cycles after the first address appeared.
- R10: Without an accepted request, `mem_ce_n` and `mem_we_n` stay 1 and `mem_dq_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 200 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, can accept |
| req_addr | input | 21 | Write address |
| req_data | input | 8 | Write data byte |
| wr_done | output | 1 | One-cycle pulse in the last cycle of a write |
| mem_addr | output | 21 | Memory address bus |
| mem_dq_o | output | 8 | Data value to drive onto the memory data lines |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read-output enable, active low |

## Verification
All pin levels are decoded from one cycle counter and one busy flag. A wrong counter value or busy state therefore changes the write strobe, chip select or data-enable in the very next cycle, or shifts `wr_done` and the return of `req_ready`. The bench's per-clock reference comparison catches such a shift on its first cycle. A wrong captured address or data byte shows on `mem_addr` one cycle after acceptance, and on `mem_dq_o` as soon as the data driver turns on. A controller that takes a request while busy shows within one cycle as a changed address in mid-write.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int TOTAL = 15,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy_q,
  output logic             busy_nxt,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    busy_nxt = busy_q;
    cnt_nxt  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_nxt = 1'b1;
        cnt_nxt  = '0;
      end
    end else if (cnt_q == LAST) begin
      busy_nxt = 1'b0;
      cnt_nxt  = '0;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  p_cnt_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));

  p_idle_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt_q == '0));

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins #(
  parameter int SU    = 1,
  parameter int PW    = 13,
  parameter int TOTAL = 15,
  parameter int CNT_W = 4,
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              busy_nxt,
  input  logic [CNT_W-1:0]  cnt_nxt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              wr_done
);

  localparam logic [CNT_W-1:0] STROBE_ON  = CNT_W'(SU);
  localparam logic [CNT_W-1:0] STROBE_OFF = CNT_W'(SU + PW);
  localparam logic [CNT_W-1:0] LAST       = CNT_W'(TOTAL - 1);

  logic strobe_win, select_win;

  always_comb begin
    strobe_win = busy_nxt && (cnt_nxt >= STROBE_ON) && (cnt_nxt < STROBE_OFF);
    select_win = busy_nxt && (cnt_nxt >= STROBE_ON) && (cnt_nxt <= STROBE_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      wr_done   <= 1'b0;
    end else begin
      if (load) begin
        mem_addr <= addr_in;
        mem_dq_o <= data_in;
      end
      mem_we_n  <= !strobe_win;
      mem_ce_n  <= !select_win;
      mem_dq_oe <= select_win;
      mem_oe_n  <= 1'b1;
      wr_done   <= busy_nxt && (cnt_nxt == LAST);
    end
  end

  // checker: length of the current write-strobe low run
  logic [CNT_W-1:0] strobe_run;
  always_ff @(posedge clk) begin
    if (!rst_n)         strobe_run <= '0;
    else if (!mem_we_n) strobe_run <= strobe_run + 1'b1;
    else                strobe_run <= '0;
  end

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (strobe_run == CNT_W'(PW)));

  p_select_covers_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_select_release_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n));

  p_driver_in_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_ce_n);

  p_no_read_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> mem_oe_n);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 5,
  parameter int T_CYCLE_NS = 70,
  parameter int T_PULSE_NS = 55,
  parameter int T_SEL_NS   = 65,
  parameter int T_ADDR_NS  = 65,
  parameter int T_DATA_NS  = 30,
  parameter int T_REC_NS   = 5,
  parameter int SETUP_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int CYC_WC  = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int CYC_WP  = ns_to_cyc(T_PULSE_NS, CLK_NS);
  localparam int CYC_CW  = ns_to_cyc(T_SEL_NS, CLK_NS);
  localparam int CYC_AW  = ns_to_cyc(T_ADDR_NS, CLK_NS);
  localparam int CYC_DW  = ns_to_cyc(T_DATA_NS, CLK_NS);
  localparam int CYC_REC = imax(ns_to_cyc(T_REC_NS, CLK_NS), 1);
  localparam int PW      = imax(imax(CYC_WP, CYC_CW),
                                imax(CYC_AW - SETUP_CYC, CYC_DW));
  localparam int TOTAL   = imax(CYC_WC, SETUP_CYC + PW + CYC_REC);
  localparam int CNT_W   = $clog2(TOTAL + 1);

  logic busy_q, busy_nxt, accept;
  logic [CNT_W-1:0] cnt_nxt;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;

  sram_wr_timer #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .busy_q   (busy_q),
    .busy_nxt (busy_nxt),
    .cnt_nxt  (cnt_nxt)
  );

  sram_wr_pins #(
    .SU(SETUP_CYC), .PW(PW), .TOTAL(TOTAL), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .addr_in   (req_addr),
    .data_in   (req_data),
    .busy_nxt  (busy_nxt),
    .cnt_nxt   (cnt_nxt),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .wr_done   (wr_done)
  );

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(mem_addr));

  p_done_then_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> req_ready);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/tb_sram_write_seq.sv
module tb_sram_write_seq;
  localparam int CLK_PERIOD = 5;
  localparam int SU = 1, PW = 13, TOTAL = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic req_ready, wr_done, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
  logic [20:0] mem_addr;
  logic [7:0]  mem_dq_o;

  int checks = 0, errors = 0, cycles = 0;
  int ph = -1;
  int writes = 0;
  logic [20:0] exp_addr = '0;
  logic [7:0]  exp_data = '0;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  sram_write_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .wr_done(wr_done),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  // behavioural reference: phase index since the accepting edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ph = -1; exp_addr = '0; exp_data = '0;
    end else if (ph < 0) begin
      if (req_valid) begin
        ph = 0; exp_addr = req_addr; exp_data = req_data; writes++;
      end
    end else if (ph == TOTAL - 1) ph = -1;
    else ph = ph + 1;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit act_win = (ph >= SU) && (ph < SU + PW);
      automatic bit sel_win = (ph >= SU) && (ph <= SU + PW);
      chk((ph < 0) ? "R2/R9" : "R2", "req_ready", req_ready, ph < 0);
      chk((ph < 0) ? "R10" : "R4", "mem_we_n", mem_we_n, !act_win);
      chk((ph < 0) ? "R10" : "R5", "mem_ce_n", mem_ce_n, !sel_win);
      chk("R6", "mem_dq_oe", mem_dq_oe, sel_win);
      if (sel_win) chk("R6", "mem_dq_o", mem_dq_o, exp_data);
      chk((writes > 1) ? "R9/R3" : "R3", "mem_addr", mem_addr, exp_addr);
      chk("R7", "mem_oe_n", mem_oe_n, 1);
      chk("R8", "wr_done", wr_done, ph == TOTAL - 1);
    end
  end

  task automatic send(input logic [20:0] a, input logic [7:0] d, input bit keep);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "mem_ce_n", mem_ce_n, 1);
    chk("R1", "mem_we_n", mem_we_n, 1);
    chk("R1", "mem_oe_n", mem_oe_n, 1);
    chk("R1", "mem_dq_oe", mem_dq_oe, 0);
    chk("R1", "wr_done", wr_done, 0);
    chk("R1", "mem_addr", mem_addr, 0);
    chk("R1", "mem_dq_o", mem_dq_o, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);            // R10 idle
    send(21'h1ABCDE, 8'hA5, 1'b0);
    repeat (20) @(negedge clk);
    send(21'h1FFFFF, 8'hFF, 1'b0);
    // R2: request presented while busy must be ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 21'h000555; req_data = 8'h3C;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    // R9: held valid, back-to-back
    send(21'h000000, 8'h00, 1'b1);
    send(21'h0F0F0F, 8'h5A, 1'b1);
    send(21'h123456, 8'hC3, 1'b0);
    repeat (30) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule